// File: doc/BRIEF.md
# Two-Level Interrupt Cause Controller

This block gathers interrupt and error events from a DMA engine into latched cause registers and turns them into interrupt requests. A primary level holds four groups: a summary group (group 0), receive completion queues (group 1), transmit completion queues (group 2) and miscellaneous events (group 3). A secondary level holds two error groups, one for transmit-side errors (group 0) and one for receive-side errors (group 1). Each secondary group rolls up into a fixed bit of primary group 3. Each group has a cause register and a mask register. A set mask bit blocks that cause from reaching the summary and the requests.

Software uses one register port. It is a single-cycle access, decoded by level (`acc_lvl_i`), group (`acc_grp_i`) and operation (`acc_op_i`). Read data is combinational while `acc_en_i` is high and `acc_wr_i` is low, and is zero otherwise. No access ever stalls. The primary level drives one of two outputs, chosen by `mode_i`: a level-sensitive line, or one-cycle request pulses on a bitmap of message vectors, where the bit position is the vector index. Transmit and receive errors can also set a sticky abort output. Each error bit has its own enables for this.

Top module: `icc_ctrl`

## Requirements
- R1: A primary cause bit in group 1, 2 or 3 is set on the clock edge after its event input is high, and stays set until it is cleared. The group 3 event inputs are mailbox inputs at bits 0–3, the timer at bit 10 and the application input at bit 11. A write with op 0 (cause) clears only the bits that are 1 in the write data. If an event and a clear hit the same bit in the same cycle, the bit stays set.
- R2: When `cor_en_i` is 1, a read with op 0 of group 1, 2 or 3, or of either secondary group, clears every bit it returned. When `cor_en_i` is 0, a read leaves the cause unchanged.
- R3: After reset, every mask bit is 1 and every cause bit is 0. The mask operations are:
  - op 1 loads the mask from the write data;
  - op 2 sets the bits written as 1;
  - op 3 clears the bits written as 1 and leaves every other mask bit unchanged.
  A read with op 1, 2 or 3 returns the mask.
- R4: A read of primary group 0 with op 0 returns a summary. Bits 0, 1 and 2 are 1 when group 1, group 2 or group 3, respectively, has any bit that is set and unmasked. Writes with op 0 to group 0 have no effect.
- R5: Primary group 3 bit 8 is 1 while secondary group 0 has any cause bit that is set and unmasked. Bit 9 does the same for secondary group 1. These two bits are live levels: clears do not affect them.
- R6: A secondary cause bit latches its error input only when the matching error-disable bit is 0.
- R7: `abort_o` rises on the edge after any error input is high with its abort-disable bit at 0, whatever the error-disable bit is. It stays high until `abort_clr_i` is applied. If a new abort error arrives in the same cycle as the clear, `abort_o` stays high.
- R8: `mode_i` values 0 and 3 select legacy mode. In legacy mode, `irq_o` is high exactly while a group 0 summary bit is 1 and its group 0 mask bit is 0. No message pulses are issued in legacy mode.
- R9: `mode_i` value 2 selects per-group mode. In this mode, vectors 0, 1 and 2 pulse for one cycle when the matching group 0 summary bit, after the group 0 mask, goes from 0 to 1. `irq_o` is held low.
- R10: `mode_i` value 1 selects per-queue mode. The vectors are:
  - vector 2 follows the masked group 3 summary;
  - vector 3+q follows receive queue q;
  - vector 3+NRX+q follows transmit queue q.
  Each vector pulses for one cycle when its source goes from 0 to 1. `irq_o` is held low.
- R11: In per-queue mode, a pulse on a queue vector sets that queue's mask bit on the same edge. If the same bit also receives a mask clear (op 3) in that cycle, the mask bit still ends up set. Mask bits that only receive the clear are cleared.
- R12: A read of a group number that does not exist returns zero, and a write to it changes nothing. The missing groups are 4–7 on the primary level and 2–3 on the secondary level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_i | input | 2 | Request mode: 0/3 legacy, 1 per-queue, 2 per-group |
| cor_en_i | input | 1 | Enables clear-on-read of cause registers |
| acc_en_i | input | 1 | Register access valid this cycle |
| acc_wr_i | input | 1 | 1 = write, 0 = read |
| acc_lvl_i | input | 1 | 0 = primary level, 1 = secondary level |
| acc_grp_i | input | 3 | Group number |
| acc_op_i | input | 2 | 0 cause, 1 mask, 2 mask set, 3 mask clear |
| acc_wdata_i | input | DW | Write data |
| acc_rdata_o | output | DW | Read data, combinational |
| rx_cmpl_i | input | NRX | Receive completion events |
| tx_cmpl_i | input | NTX | Transmit completion events |
| mbox_i | input | 4 | Mailbox events |
| timer_i | input | 1 | Software timer event |
| app_i | input | 1 | External application event |
| tx_err_i | input | WA | Transmit-side error events |
| tx_err_dis_i | input | WA | Per-bit transmit error disable |
| tx_abt_dis_i | input | WA | Per-bit transmit abort disable |
| rx_err_i | input | WB | Receive-side error events |
| rx_err_dis_i | input | WB | Per-bit receive error disable |
| rx_abt_dis_i | input | WB | Per-bit receive abort disable |
| abort_clr_i | input | 1 | Clears the sticky abort |
| irq_o | output | 1 | Legacy level interrupt |
| msg_req_o | output | 3+NRX+NTX | One-cycle message vector requests, bit index = vector |
| abort_o | output | 1 | Sticky engine abort |

## Verification
A corrupted cause or mask bit becomes visible at the ports in the same cycle. It appears in the combinational read data when that group is read. In legacy mode it also changes `irq_o`. In the message modes, any pending bit that turns on produces a spurious or missing pulse on `msg_req_o`.

A lost edge-detect history shows up as repeated or absent pulses one cycle later. A wrong abort state shows on `abort_o` on the edge after the error or the clear.

The bench compares read data, `irq_o`, `msg_req_o` and `abort_o` against a behavioural model on every cycle. Long random stretches also read back every group often enough that hidden state cannot stay hidden for long.

// File: rtl/icc_pkg.sv
package icc_pkg;
  typedef enum logic [1:0] {
    OP_CAUSE = 2'd0,
    OP_MASK  = 2'd1,
    OP_MSET  = 2'd2,
    OP_MCLR  = 2'd3
  } icc_op_e;

  typedef enum logic [1:0] {
    MODE_LEGACY  = 2'd0,
    MODE_PERQ    = 2'd1,
    MODE_PERGRP  = 2'd2,
    MODE_LEGACY2 = 2'd3
  } icc_mode_e;

  localparam int G3_W       = 12;
  localparam int G3_TX_SUM  = 8;
  localparam int G3_RX_SUM  = 9;
  localparam int VEC_G3     = 2;
  localparam int VEC_RX0    = 3;
  localparam int SUM_W      = 3;
endpackage

// File: rtl/icc_group.sv
module icc_group
  import icc_pkg::*;
#(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_i,
  input  logic         sel_i,
  input  logic         wr_i,
  input  icc_op_e      op_i,
  input  logic [W-1:0] wdata_i,
  input  logic         cor_i,
  input  logic [W-1:0] amask_i,
  output logic [W-1:0] cause_o,
  output logic [W-1:0] mask_o
);
  logic [W-1:0] cause_q, mask_q, cause_d, mask_d, clr;

  always_comb begin
    clr = '0;
    if (sel_i && op_i == OP_CAUSE) begin
      if (wr_i)       clr = wdata_i;
      else if (cor_i) clr = cause_q;
    end
    cause_d = (cause_q & ~clr) | set_i;
  end

  always_comb begin
    mask_d = mask_q;
    if (sel_i && wr_i) begin
      case (op_i)
        OP_MASK: mask_d = wdata_i;
        OP_MSET: mask_d = mask_q | wdata_i;
        OP_MCLR: mask_d = mask_q & ~wdata_i;
        default: mask_d = mask_q;
      endcase
    end
    mask_d = mask_d | amask_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cause_q <= '0;
      mask_q  <= '1;
    end else begin
      cause_q <= cause_d;
      mask_q  <= mask_d;
    end
  end

  assign cause_o = cause_q;
  assign mask_o  = mask_q;
endmodule

// File: rtl/icc_pulse.sv
module icc_pulse #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] lvl_i,
  output logic [N-1:0] pulse_o
);
  logic [N-1:0] lvl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lvl_q <= '0;
    else        lvl_q <= lvl_i;
  end

  assign pulse_o = lvl_i & ~lvl_q;
endmodule

// File: rtl/icc_ctrl.sv
module icc_ctrl
  import icc_pkg::*;
#(
  parameter int DW  = 32,
  parameter int NRX = 4,
  parameter int NTX = 4,
  parameter int WA  = 28,
  parameter int WB  = 32,
  localparam int NVEC = VEC_RX0 + NRX + NTX
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [1:0]      mode_i,
  input  logic            cor_en_i,
  input  logic            acc_en_i,
  input  logic            acc_wr_i,
  input  logic            acc_lvl_i,
  input  logic [2:0]      acc_grp_i,
  input  logic [1:0]      acc_op_i,
  input  logic [DW-1:0]   acc_wdata_i,
  output logic [DW-1:0]   acc_rdata_o,
  input  logic [NRX-1:0]  rx_cmpl_i,
  input  logic [NTX-1:0]  tx_cmpl_i,
  input  logic [3:0]      mbox_i,
  input  logic            timer_i,
  input  logic            app_i,
  input  logic [WA-1:0]   tx_err_i,
  input  logic [WA-1:0]   tx_err_dis_i,
  input  logic [WA-1:0]   tx_abt_dis_i,
  input  logic [WB-1:0]   rx_err_i,
  input  logic [WB-1:0]   rx_err_dis_i,
  input  logic [WB-1:0]   rx_abt_dis_i,
  input  logic            abort_clr_i,
  output logic            irq_o,
  output logic [NVEC-1:0] msg_req_o,
  output logic            abort_o
);
  icc_op_e   op;
  icc_mode_e mode;
  assign op   = icc_op_e'(acc_op_i);
  assign mode = icc_mode_e'(mode_i);

  logic       rd;
  logic [3:0] psel;
  logic [1:0] ssel;
  assign rd = acc_en_i && !acc_wr_i;

  for (genvar g = 0; g < 4; g++) begin : g_psel
    assign psel[g] = acc_en_i && !acc_lvl_i && (acc_grp_i == 3'(g));
  end
  for (genvar g = 0; g < 2; g++) begin : g_ssel
    assign ssel[g] = acc_en_i && acc_lvl_i && (acc_grp_i == 3'(g));
  end

  logic [SUM_W-1:0] c0, m0;
  logic [NRX-1:0]   c1, m1, am1;
  logic [NTX-1:0]   c2, m2, am2;
  logic [G3_W-1:0]  c3, m3, set3, eff3;
  logic [WA-1:0]    ca, ma;
  logic [WB-1:0]    cb, mb;
  logic [SUM_W-1:0] sum, sum_pend;
  logic [NVEC-1:0]  vlev, pulse;
  logic             sa, sb, legacy;

  assign set3 = {app_i, timer_i, 6'b0, mbox_i};

  icc_group #(.W(SUM_W)) u_g0 (
    .clk, .rst_n, .set_i('0), .sel_i(psel[0]), .wr_i(acc_wr_i), .op_i(op),
    .wdata_i(acc_wdata_i[SUM_W-1:0]), .cor_i(cor_en_i), .amask_i('0),
    .cause_o(c0), .mask_o(m0));
  icc_group #(.W(NRX)) u_g1 (
    .clk, .rst_n, .set_i(rx_cmpl_i), .sel_i(psel[1]), .wr_i(acc_wr_i), .op_i(op),
    .wdata_i(acc_wdata_i[NRX-1:0]), .cor_i(cor_en_i), .amask_i(am1),
    .cause_o(c1), .mask_o(m1));
  icc_group #(.W(NTX)) u_g2 (
    .clk, .rst_n, .set_i(tx_cmpl_i), .sel_i(psel[2]), .wr_i(acc_wr_i), .op_i(op),
    .wdata_i(acc_wdata_i[NTX-1:0]), .cor_i(cor_en_i), .amask_i(am2),
    .cause_o(c2), .mask_o(m2));
  icc_group #(.W(G3_W)) u_g3 (
    .clk, .rst_n, .set_i(set3), .sel_i(psel[3]), .wr_i(acc_wr_i), .op_i(op),
    .wdata_i(acc_wdata_i[G3_W-1:0]), .cor_i(cor_en_i), .amask_i('0),
    .cause_o(c3), .mask_o(m3));
  icc_group #(.W(WA)) u_sa (
    .clk, .rst_n, .set_i(tx_err_i & ~tx_err_dis_i), .sel_i(ssel[0]), .wr_i(acc_wr_i),
    .op_i(op), .wdata_i(acc_wdata_i[WA-1:0]), .cor_i(cor_en_i), .amask_i('0),
    .cause_o(ca), .mask_o(ma));
  icc_group #(.W(WB)) u_sb (
    .clk, .rst_n, .set_i(rx_err_i & ~rx_err_dis_i), .sel_i(ssel[1]), .wr_i(acc_wr_i),
    .op_i(op), .wdata_i(acc_wdata_i[WB-1:0]), .cor_i(cor_en_i), .amask_i('0),
    .cause_o(cb), .mask_o(mb));

  // secondary roll-up into live bits of group 3
  assign sa = |(ca & ~ma);
  assign sb = |(cb & ~mb);
  always_comb begin
    eff3            = c3;
    eff3[G3_TX_SUM] = sa;
    eff3[G3_RX_SUM] = sb;
  end

  assign sum      = {|(eff3 & ~m3), |(c2 & ~m2), |(c1 & ~m1)} | c0;
  assign sum_pend = sum & ~m0;
  assign legacy   = (mode == MODE_LEGACY) || (mode == MODE_LEGACY2);
  assign irq_o    = legacy && |sum_pend;

  always_comb begin
    vlev = '0;
    if (mode == MODE_PERGRP) begin
      vlev[SUM_W-1:0] = sum_pend;
    end else if (mode == MODE_PERQ) begin
      vlev[VEC_G3]              = sum_pend[2];
      vlev[VEC_RX0 +: NRX]      = c1 & ~m1;
      vlev[VEC_RX0+NRX +: NTX]  = c2 & ~m2;
    end
  end

  icc_pulse #(.N(NVEC)) u_pulse (.clk, .rst_n, .lvl_i(vlev), .pulse_o(pulse));
  assign msg_req_o = pulse;
  assign am1 = (mode == MODE_PERQ) ? pulse[VEC_RX0 +: NRX]     : '0;
  assign am2 = (mode == MODE_PERQ) ? pulse[VEC_RX0+NRX +: NTX] : '0;

  // sticky abort, new error beats clear
  logic abort_q, abort_set;
  assign abort_set = |(tx_err_i & ~tx_abt_dis_i) || |(rx_err_i & ~rx_abt_dis_i);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) abort_q <= 1'b0;
    else        abort_q <= (abort_q && !abort_clr_i) || abort_set;
  end
  assign abort_o = abort_q;

  function automatic logic [DW-1:0] pick(logic [DW-1:0] c, logic [DW-1:0] m);
    return (op == OP_CAUSE) ? c : m;
  endfunction

  always_comb begin
    acc_rdata_o = '0;
    if (rd) begin
      if (!acc_lvl_i) begin
        case (acc_grp_i)
          3'd0:    acc_rdata_o = pick(DW'(sum),  DW'(m0));
          3'd1:    acc_rdata_o = pick(DW'(c1),   DW'(m1));
          3'd2:    acc_rdata_o = pick(DW'(c2),   DW'(m2));
          3'd3:    acc_rdata_o = pick(DW'(eff3), DW'(m3));
          default: acc_rdata_o = '0;
        endcase
      end else begin
        case (acc_grp_i)
          3'd0:    acc_rdata_o = pick(DW'(ca), DW'(ma));
          3'd1:    acc_rdata_o = pick(DW'(cb), DW'(mb));
          default: acc_rdata_o = '0;
        endcase
      end
    end
  end
endmodule

// File: rtl/icc_checker.sv
module icc_checker #(
  parameter int DW  = 32,
  parameter int NRX = 4,
  parameter int NTX = 4,
  parameter int WA  = 28,
  parameter int WB  = 32,
  localparam int NVEC = 3 + NRX + NTX
) (
  input logic            clk,
  input logic            rst_n,
  input logic [1:0]      mode_i,
  input logic            acc_en_i,
  input logic            acc_wr_i,
  input logic            acc_lvl_i,
  input logic [2:0]      acc_grp_i,
  input logic [DW-1:0]   acc_rdata_o,
  input logic [WA-1:0]   tx_err_i,
  input logic [WA-1:0]   tx_abt_dis_i,
  input logic [WB-1:0]   rx_err_i,
  input logic [WB-1:0]   rx_abt_dis_i,
  input logic            abort_clr_i,
  input logic            irq_o,
  input logic [NVEC-1:0] msg_req_o,
  input logic            abort_o
);
  logic leg, oor;
  assign leg = (mode_i == 2'd0) || (mode_i == 2'd3);
  assign oor = acc_lvl_i ? (acc_grp_i >= 3'd2) : (acc_grp_i >= 3'd4);

  AST_ABORT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    abort_o && !abort_clr_i |=> abort_o); // R7
  AST_ABORT_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(abort_o) |-> $past(|(tx_err_i & ~tx_abt_dis_i) || |(rx_err_i & ~rx_abt_dis_i))); // R7
  AST_LEGACY_NO_MSG: assert property (@(posedge clk) disable iff (!rst_n)
    leg |-> msg_req_o == '0); // R8
  AST_MSG_NO_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    !leg |-> !irq_o); // R9
  AST_PERGRP_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    mode_i == 2'd2 |-> msg_req_o[NVEC-1:3] == '0); // R9
  AST_MSG_ONESHOT: assert property (@(posedge clk) disable iff (!rst_n)
    |msg_req_o |=> (msg_req_o & $past(msg_req_o)) == '0); // R10
  AST_OOR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    acc_en_i && !acc_wr_i && oor |-> acc_rdata_o == '0); // R12
endmodule

bind icc_ctrl icc_checker #(.DW(DW), .NRX(NRX), .NTX(NTX), .WA(WA), .WB(WB)) u_chk (.*);

// File: tb/icc_ctrl_bench.sv
module icc_ctrl_bench;
  localparam int PERIOD = 10;
  localparam int DW = 32, NRX = 4, NTX = 4, WA = 28, WB = 32;
  localparam int NVEC = 3 + NRX + NTX;
  localparam logic [31:0] WM0 = 32'h7, WM1 = 32'hF, WM2 = 32'hF, WM3 = 32'hFFF;
  localparam logic [31:0] WMA = 32'h0FFF_FFFF, WMB = 32'hFFFF_FFFF;

  logic clk = 0, rst_n = 0;
  logic [1:0] mode = 0;
  logic cor_en = 0, acc_en = 0, acc_wr = 0, acc_lvl = 0;
  logic [2:0] acc_grp = 0;
  logic [1:0] acc_op = 0;
  logic [31:0] acc_wdata = 0, acc_rdata;
  logic [NRX-1:0] rx_cmpl = 0;
  logic [NTX-1:0] tx_cmpl = 0;
  logic [3:0] mbox = 0;
  logic timer = 0, app = 0, abort_clr = 0;
  logic [WA-1:0] tx_err = 0, tx_dis = 0, tx_abt = '1;
  logic [WB-1:0] rx_err = 0, rx_dis = 0, rx_abt = '1;
  logic irq, abort;
  logic [NVEC-1:0] msg;

  always #(PERIOD/2) clk = ~clk;

  icc_ctrl #(.DW(DW), .NRX(NRX), .NTX(NTX), .WA(WA), .WB(WB)) u_icc_ctrl (
    .clk, .rst_n, .mode_i(mode), .cor_en_i(cor_en), .acc_en_i(acc_en), .acc_wr_i(acc_wr),
    .acc_lvl_i(acc_lvl), .acc_grp_i(acc_grp), .acc_op_i(acc_op), .acc_wdata_i(acc_wdata),
    .acc_rdata_o(acc_rdata), .rx_cmpl_i(rx_cmpl), .tx_cmpl_i(tx_cmpl), .mbox_i(mbox),
    .timer_i(timer), .app_i(app), .tx_err_i(tx_err), .tx_err_dis_i(tx_dis),
    .tx_abt_dis_i(tx_abt), .rx_err_i(rx_err), .rx_err_dis_i(rx_dis), .rx_abt_dis_i(rx_abt),
    .abort_clr_i(abort_clr), .irq_o(irq), .msg_req_o(msg), .abort_o(abort));

  // behavioural reference model
  logic [31:0] mc1, mc2, mc3, mm0, mm1, mm2, mm3, sca, scb, sma, smb;
  logic mab;
  logic [NVEC-1:0] mlv;
  int vectors = 0, fails = 0;
  string phase = "R3";

  task automatic mreset();
    mc1 = 0; mc2 = 0; mc3 = 0; sca = 0; scb = 0;
    mm0 = WM0; mm1 = WM1; mm2 = WM2; mm3 = WM3; sma = WMA; smb = WMB;
    mab = 0; mlv = 0;
  endtask

  function automatic logic [31:0] g3eff();
    logic [31:0] v = mc3;
    v[8] = |(sca & ~sma);
    v[9] = |(scb & ~smb);
    return v;
  endfunction

  function automatic logic [2:0] sums();
    return {|(g3eff() & ~mm3), |(mc2 & ~mm2), |(mc1 & ~mm1)};
  endfunction

  function automatic logic [NVEC-1:0] vlev();
    logic [NVEC-1:0] v = '0;
    logic [2:0] p = sums() & ~mm0[2:0];
    if (mode == 2) v[2:0] = p;
    else if (mode == 1) begin
      v[2] = p[2];
      for (int q = 0; q < NRX; q++) v[3+q] = mc1[q] & ~mm1[q];
      for (int q = 0; q < NTX; q++) v[3+NRX+q] = mc2[q] & ~mm2[q];
    end
    return v;
  endfunction

  function automatic logic [31:0] rdexp();
    logic [31:0] c, m;
    if (!acc_en || acc_wr) return 0;
    if (!acc_lvl) begin
      case (acc_grp)
        0: begin c = {29'b0, sums()}; m = mm0; end
        1: begin c = mc1; m = mm1; end
        2: begin c = mc2; m = mm2; end
        3: begin c = g3eff(); m = mm3; end
        default: return 0;
      endcase
    end else begin
      case (acc_grp)
        0: begin c = sca; m = sma; end
        1: begin c = scb; m = smb; end
        default: return 0;
      endcase
    end
    return (acc_op == 0) ? c : m;
  endfunction

  function automatic logic hit(logic l, int g);
    return acc_en && acc_lvl == l && acc_grp == 3'(g);
  endfunction

  function automatic logic [31:0] nc(logic [31:0] cur, logic h, logic [31:0] st, logic [31:0] wm);
    logic [31:0] clr = 0;
    if (h && acc_op == 0) begin
      if (acc_wr) clr = acc_wdata;
      else if (cor_en) clr = cur;
    end
    return ((cur & ~clr) | st) & wm;
  endfunction

  function automatic logic [31:0] nm(logic [31:0] cur, logic h, logic [31:0] wm);
    logic [31:0] r = cur;
    if (h && acc_wr) begin
      case (acc_op)
        1: r = acc_wdata;
        2: r = cur | acc_wdata;
        3: r = cur & ~acc_wdata;
        default: r = cur;
      endcase
    end
    return r & wm;
  endfunction

  initial mreset();

  always @(posedge clk) begin
    if (!rst_n) mreset();
    else begin
      logic [NVEC-1:0] v, pl;
      v  = vlev();
      pl = v & ~mlv;
      mc1 = nc(mc1, hit(0, 1), 32'(rx_cmpl), WM1);
      mc2 = nc(mc2, hit(0, 2), 32'(tx_cmpl), WM2);
      mc3 = nc(mc3, hit(0, 3), {20'b0, app, timer, 6'b0, mbox}, WM3);
      sca = nc(sca, hit(1, 0), 32'(tx_err & ~tx_dis), WMA);
      scb = nc(scb, hit(1, 1), 32'(rx_err & ~rx_dis), WMB);
      mm0 = nm(mm0, hit(0, 0), WM0);
      mm1 = nm(mm1, hit(0, 1), WM1);
      mm2 = nm(mm2, hit(0, 2), WM2);
      mm3 = nm(mm3, hit(0, 3), WM3);
      sma = nm(sma, hit(1, 0), WMA);
      smb = nm(smb, hit(1, 1), WMB);
      if (mode == 1) begin   // R11 auto-mask wins
        mm1 = mm1 | (32'(pl >> 3) & WM1);
        mm2 = mm2 | (32'(pl >> (3 + NRX)) & WM2);
      end
      mab = (mab && !abort_clr) || |(tx_err & ~tx_abt) || |(rx_err & ~rx_abt);
      mlv = v;
    end
  end

  always @(negedge clk) begin
    logic [31:0] er;
    logic [NVEC-1:0] em;
    logic ei;
    er = rdexp();
    em = vlev() & ~mlv;
    ei = (mode == 0 || mode == 3) && |(sums() & ~mm0[2:0]);
    vectors++;
    if (acc_rdata !== er) begin
      fails++; $display("FAIL %s rdata got %h exp %h", phase, acc_rdata, er);
    end
    if (irq !== ei) begin
      fails++; $display("FAIL %s irq got %b exp %b", phase, irq, ei);
    end
    if (msg !== em) begin
      fails++; $display("FAIL %s msg got %b exp %b", phase, msg, em);
    end
    if (abort !== mab) begin
      fails++; $display("FAIL %s abort got %b exp %b", phase, abort, mab);
    end
  end

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic acc(input logic wr, input logic lvl, input int grp, input int op,
                     input logic [31:0] wd);
    acc_en = 1; acc_wr = wr; acc_lvl = lvl; acc_grp = 3'(grp); acc_op = 2'(op);
    acc_wdata = wd;
    tick();
    acc_en = 0; acc_wr = 0;
  endtask

  initial begin
    #(PERIOD * 150000);
    fails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    tick(); tick(); rst_n = 1; tick();
    // R3 reset values and mask operations
    phase = "R3";
    acc(0, 0, 1, 1, 0); acc(0, 0, 1, 0, 0);
    acc(1, 0, 2, 1, 32'h5); acc(1, 0, 2, 2, 32'h2); acc(1, 0, 2, 3, 32'h4);
    acc(0, 0, 2, 3, 0);
    // R1 latching, write clear, set beats clear
    phase = "R1";
    rx_cmpl = 4'b0101; tick(); rx_cmpl = 0;
    acc(0, 0, 1, 0, 0); acc(1, 0, 1, 0, 32'h1);
    rx_cmpl = 4'b0100; acc(1, 0, 1, 0, 32'h4); rx_cmpl = 0;
    acc(0, 0, 1, 0, 0);
    // R2 clear-on-read
    phase = "R2";
    acc(0, 0, 1, 0, 0);
    cor_en = 1; acc(0, 0, 1, 0, 0); acc(0, 0, 1, 0, 0); cor_en = 0;
    // R8 legacy line
    phase = "R8";
    mode = 0; acc(1, 0, 0, 1, 0); acc(1, 0, 1, 3, 32'h1);
    rx_cmpl = 1; tick(); rx_cmpl = 0; tick(); tick();
    mode = 3; tick(); acc(1, 0, 1, 0, 32'hF); tick();
    // R4 summary group, cause writes ignored
    phase = "R4";
    acc(1, 0, 2, 1, 0); tx_cmpl = 4'h2; tick(); tx_cmpl = 0;
    acc(1, 0, 0, 0, 32'h7); acc(0, 0, 0, 0, 0);
    // R6 secondary error disable
    phase = "R6";
    acc(1, 1, 0, 1, 0);
    tx_dis = 28'h0F; tx_err = 28'h33; tick(); tx_err = 0;
    acc(0, 1, 0, 0, 0); tx_dis = 0;
    // R5 group 3 bits and live roll-up
    phase = "R5";
    acc(0, 0, 3, 0, 0);
    mbox = 4'hA; timer = 1; app = 1; tick(); mbox = 0; timer = 0; app = 0;
    acc(0, 0, 3, 0, 0); acc(1, 0, 3, 3, 32'h300); tick();
    acc(1, 0, 3, 0, 32'hFFF); acc(0, 0, 3, 0, 0);
    acc(1, 1, 0, 0, 32'hFFFF_FFFF); acc(0, 0, 3, 0, 0);
    // R7 sticky abort
    phase = "R7";
    tx_abt = 28'hFFF_FFFE; tx_err = 28'h2; tick(); tx_err = 28'h1; tick(); tx_err = 0;
    tick(); tick(); abort_clr = 1; tick();
    tx_err = 28'h1; tick(); tx_err = 0; tick(); tick(); abort_clr = 0; tick();
    tx_abt = '1;
    // R9 per-group vectors
    phase = "R9";
    mode = 2; acc(1, 0, 2, 1, 0); tx_cmpl = 4'h3; tick(); tx_cmpl = 0; tick(); tick();
    acc(1, 0, 0, 2, 32'h2); acc(1, 0, 0, 3, 32'h2); tick();
    // R10 per-queue vectors
    phase = "R10";
    mode = 1; acc(1, 0, 2, 0, 32'hF); acc(1, 0, 1, 1, 0);
    rx_cmpl = 4'h8; tick(); rx_cmpl = 0; tick();
    tx_cmpl = 4'h4; tick(); tx_cmpl = 0; tick();
    mbox = 4'h1; tick(); mbox = 0; tick();
    // R11 auto-mask against same-cycle mask clear
    phase = "R11";
    acc(1, 0, 1, 0, 32'hF); acc(1, 0, 1, 1, 32'hE);
    rx_cmpl = 4'h1; tick(); rx_cmpl = 0;
    acc(1, 0, 1, 3, 32'h3); acc(0, 0, 1, 1, 0);
    // R12 missing groups
    phase = "R12";
    acc(0, 0, 5, 0, 0); acc(1, 1, 2, 1, 0); acc(0, 1, 3, 1, 0);
    acc(1, 0, 7, 1, 0); acc(0, 0, 4, 1, 0); acc(0, 1, 0, 1, 0);
    // random traffic across all requirements
    phase = "R1";
    for (int i = 0; i < 4000; i++) begin
      if (i % 256 == 0) begin
        mode   = 2'($urandom);
        cor_en = 1'($urandom);
        tx_dis = WA'($urandom); tx_abt = WA'($urandom | $urandom);
        rx_dis = WB'($urandom); rx_abt = WB'($urandom | $urandom);
      end
      rx_cmpl   = ($urandom % 4 == 0) ? NRX'($urandom) : '0;
      tx_cmpl   = ($urandom % 4 == 0) ? NTX'($urandom) : '0;
      mbox      = ($urandom % 8 == 0) ? 4'($urandom) : '0;
      timer     = ($urandom % 16 == 0);
      app       = ($urandom % 16 == 0);
      tx_err    = ($urandom % 16 == 0) ? WA'($urandom) : '0;
      rx_err    = ($urandom % 16 == 0) ? WB'($urandom) : '0;
      abort_clr = ($urandom % 8 == 0);
      acc_en    = ($urandom % 2 == 0);
      acc_wr    = ($urandom % 3 == 0);
      acc_lvl   = ($urandom % 4 == 0);
      acc_grp   = ($urandom % 8 == 0) ? 3'($urandom) : 3'($urandom % 4);
      acc_op    = 2'($urandom);
      acc_wdata = $urandom;
      tick();
    end
    acc_en = 0;
    tick(); tick();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule